// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block passes data between two word-wide ports, A and B, through two independent storage paths: one carries A toward B, the other carries B toward A. Each path has a single storage element. A run-time latch enable picks how it behaves. With the enable high, the path is a transparent pass-through. With the enable low, the element is an edge-triggered register whose clock is gated by an active-low clock enable.

Each receiving port is modelled as a data bus plus a drive flag, controlled by an active-low output enable. A released port reports its drive flag low and presents all zeros on its data bus. Surrounding logic or pad cells can then build the real tri-state buffer.

The two paths share no state. The only thing they have in common is a synchronous active-high reset. Each path samples that reset on its own clock.

Top module: `xcvr_bidir`

## Requirements
- R1: While a path's latch enable is high and its output enable is low, the receiving port carries that path's input word combinationally, with no clock edge needed.
- R2: While the latch enable is low and no rising edge occurs on the path clock, the receiving port keeps showing the stored word, even when the input changes.
- R3: With the latch enable low and the active-low clock enable at 0, a rising edge of the path clock stores the input word, and the port shows it from then on.
- R4: With the latch enable low and the clock enable at 1, rising edges of the path clock leave the stored word unchanged.
- R5: While the latch enable is high, each rising edge of the path clock loads the input word whatever the clock enable is. When the latch enable then falls, the port shows the last word loaded.
- R6: With the output enable at 1, the port's drive flag is 0 and its data bus is all zeros. With the output enable at 0, the drive flag is 1. Releasing the port does not alter the stored word.
- R7: When reset is high at a rising edge of a path clock, that path's stored word clears to zero, overriding every other control. The other path is untouched until its own clock rises.
- R8: Controls, clocks and data of one path never change what the other path stores or drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, sampled on each path clock |
| clk_ab | input | 1 | A-to-B path clock |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| cken_ab_n | input | 1 | A-to-B clock enable, active low |
| oe_ab_n | input | 1 | B-port output enable, active low |
| a_in | input | W | Word arriving on port A |
| b_out | output | W | Word presented on port B (zero when released) |
| b_drive | output | 1 | B port drive flag |
| clk_ba | input | 1 | B-to-A path clock |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| cken_ba_n | input | 1 | B-to-A clock enable, active low |
| oe_ba_n | input | 1 | A-port output enable, active low |
| b_in | input | W | Word arriving on port B |
| a_out | output | W | Word presented on port A (zero when released) |
| a_drive | output | 1 | A port drive flag |

## Verification
The transparent path and the output enable act with zero latency, so the port reflects them in the same cycle they change. Stored words are due right after the rising path-clock edge that loads them. The bench changes inputs and path clocks only on falling edges of its own clock. It samples both ports on the next rising edge, half a period later, when every path-clock register has settled. A behavioural model updates on the same path-clock edges, so every cycle is compared against a due value, and scripted corner cases add checks with fixed expected words.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR,
    OP_TRACK,
    OP_LOAD,
    OP_KEEP
  } store_op_e;

  // Reset wins, then transparency tracking, then gated capture.
  function automatic store_op_e pick_op(input logic rst, input logic le,
                                        input logic cken_n);
    if (rst)          return OP_CLEAR;
    else if (le)      return OP_TRACK;
    else if (!cken_n) return OP_LOAD;
    else              return OP_KEEP;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         cken_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  store_op_e op;

  always_comb op = pick_op(rst, le, cken_n);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q <= '0;
      OP_TRACK,
      OP_LOAD:  q <= din;
      default:  q <= q;
    endcase
  end

endmodule

// File: rtl/xcvr_outstage.sv
module xcvr_outstage #(
  parameter int W = 18
) (
  input  logic         le,
  input  logic         oe_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] q,
  output logic [W-1:0] dout,
  output logic         drive
);

  logic [W-1:0] view;

  always_comb begin
    view  = le ? din : q;
    drive = ~oe_n;
    dout  = oe_n ? '0 : view;
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         cken_n,
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive,
  output logic [W-1:0] held
);

  xcvr_store #(.W(W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .le     (le),
    .cken_n (cken_n),
    .din    (din),
    .q      (held)
  );

  xcvr_outstage #(.W(W)) u_out (
    .le    (le),
    .oe_n  (oe_n),
    .din   (din),
    .q     (held),
    .dout  (dout),
    .drive (drive)
  );

endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir #(
  parameter int W = 18
) (
  input  logic         rst,
  input  logic         clk_ab,
  input  logic         le_ab,
  input  logic         cken_ab_n,
  input  logic         oe_ab_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         clk_ba,
  input  logic         le_ba,
  input  logic         cken_ba_n,
  input  logic         oe_ba_n,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  localparam int NPATH = 2;   // index 0: A toward B, index 1: B toward A

  logic         clk_v    [NPATH];
  logic         le_v     [NPATH];
  logic         cken_n_v [NPATH];
  logic         oe_n_v   [NPATH];
  logic [W-1:0] din_v    [NPATH];
  logic [W-1:0] dout_v   [NPATH];
  logic         drive_v  [NPATH];
  logic [W-1:0] held_v   [NPATH];
  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  always_comb begin
    clk_v[0] = clk_ab;    clk_v[1] = clk_ba;
    le_v[0]  = le_ab;     le_v[1]  = le_ba;
    cken_n_v[0] = cken_ab_n;
    cken_n_v[1] = cken_ba_n;
    oe_n_v[0] = oe_ab_n;  oe_n_v[1] = oe_ba_n;
    din_v[0] = a_in;      din_v[1] = b_in;
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    xcvr_path #(.W(W)) u_path (
      .clk    (clk_v[p]),
      .rst    (rst),
      .le     (le_v[p]),
      .cken_n (cken_n_v[p]),
      .oe_n   (oe_n_v[p]),
      .din    (din_v[p]),
      .dout   (dout_v[p]),
      .drive  (drive_v[p]),
      .held   (held_v[p])
    );
  end

  assign b_out   = dout_v[0];
  assign b_drive = drive_v[0];
  assign a_out   = dout_v[1];
  assign a_drive = drive_v[1];
  assign held_ab = held_v[0];
  assign held_ba = held_v[1];

endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
  parameter int W = 18
) (
  input logic         rst,
  input logic         clk_ab,
  input logic         le_ab,
  input logic         cken_ab_n,
  input logic         oe_ab_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic         clk_ba,
  input logic         le_ba,
  input logic         cken_ba_n,
  input logic         oe_ba_n,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] held_ab,
  input logic [W-1:0] held_ba
);

  assert_pass_ab_R1: assert property (@(posedge clk_ab) disable iff (rst)
    (le_ab && !oe_ab_n) |-> (b_out == a_in));
  assert_pass_ba_R1: assert property (@(posedge clk_ba) disable iff (rst)
    (le_ba && !oe_ba_n) |-> (a_out == b_in));

  assert_capture_ab_R3: assert property (@(posedge clk_ab) disable iff (rst)
    (!le_ab && !cken_ab_n) |=> (held_ab == $past(a_in)));
  assert_capture_ba_R3: assert property (@(posedge clk_ba) disable iff (rst)
    (!le_ba && !cken_ba_n) |=> (held_ba == $past(b_in)));

  assert_gated_ab_R4: assert property (@(posedge clk_ab) disable iff (rst)
    (!le_ab && cken_ab_n) |=> $stable(held_ab));
  assert_gated_ba_R4: assert property (@(posedge clk_ba) disable iff (rst)
    (!le_ba && cken_ba_n) |=> $stable(held_ba));

  assert_track_ab_R5: assert property (@(posedge clk_ab) disable iff (rst)
    le_ab |=> (held_ab == $past(a_in)));
  assert_track_ba_R5: assert property (@(posedge clk_ba) disable iff (rst)
    le_ba |=> (held_ba == $past(b_in)));

  assert_release_b_R6: assert property (@(posedge clk_ab) disable iff (rst)
    oe_ab_n |-> (!b_drive && b_out == '0));
  assert_release_a_R6: assert property (@(posedge clk_ba) disable iff (rst)
    oe_ba_n |-> (!a_drive && a_out == '0));

endmodule

bind xcvr_bidir xcvr_bidir_chk #(.W(W)) u_chk (.*);

// File: tb/xcvr_bidir_tb.sv
module xcvr_bidir_tb;

  localparam int W = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic         clk_ab = 1'b0, le_ab = 1'b0, cken_ab_n = 1'b0, oe_ab_n = 1'b0;
  logic         clk_ba = 1'b0, le_ba = 1'b0, cken_ba_n = 1'b0, oe_ba_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  xcvr_bidir #(.W(W)) u_dut (
    .rst(rst), .clk_ab(clk_ab), .le_ab(le_ab), .cken_ab_n(cken_ab_n),
    .oe_ab_n(oe_ab_n), .a_in(a_in), .b_out(b_out), .b_drive(b_drive),
    .clk_ba(clk_ba), .le_ba(le_ba), .cken_ba_n(cken_ba_n),
    .oe_ba_n(oe_ba_n), .b_in(b_in), .a_out(a_out), .a_drive(a_drive)
  );

  // Behavioural reference: one stored word per direction.
  logic [W-1:0] mdl_ab = '0, mdl_ba = '0;

  always @(posedge clk_ab) begin
    if (rst) mdl_ab <= '0;
    else if (le_ab || !cken_ab_n) mdl_ab <= a_in;
  end

  always @(posedge clk_ba) begin
    if (rst) mdl_ba <= '0;
    else if (le_ba || !cken_ba_n) mdl_ba <= b_in;
  end

  task automatic chk(input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic oe_n, input logic le);
    if (oe_n) return "R6";
    if (le)   return "R1";
    return "R2";
  endfunction

  // Every-cycle comparison against the model (after reset has been applied).
  bit model_live = 1'b0;
  always @(posedge clk) begin
    cycles++;
    if (model_live && !rst) begin
      chk(tag_of(oe_ab_n, le_ab), b_out,
          oe_ab_n ? '0 : (le_ab ? a_in : mdl_ab));
      chk(tag_of(oe_ab_n, le_ab), {{(W-1){1'b0}}, b_drive},
          {{(W-1){1'b0}}, ~oe_ab_n});
      chk(tag_of(oe_ba_n, le_ba), a_out,
          oe_ba_n ? '0 : (le_ba ? b_in : mdl_ba));
      chk(tag_of(oe_ba_n, le_ba), {{(W-1){1'b0}}, a_drive},
          {{(W-1){1'b0}}, ~oe_ba_n});
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_ab();
    @(negedge clk) clk_ab = 1'b1;
    @(negedge clk) clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk) clk_ba = 1'b1;
    @(negedge clk) clk_ba = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
  endtask

  initial begin
    // Reset applied on both path clocks.
    pulse_ab(); pulse_ba(); pulse_ab(); pulse_ba();
    settle();
    chk("R7 reset b_out", b_out, '0);
    chk("R7 reset a_out", a_out, '0);
    @(negedge clk) rst = 1'b0;
    model_live = 1'b1;

    // R1 transparent following without clocks
    @(negedge clk) begin le_ab = 1'b1; a_in = 18'h15A5A; end
    settle();
    chk("R1 transparent", b_out, 18'h15A5A);
    @(negedge clk) a_in = 18'h2F00F;
    settle();
    chk("R1 transparent follow", b_out, 18'h2F00F);

    // R5 tracking load with clock enable high, then latch enable falls
    @(negedge clk) cken_ab_n = 1'b1;
    pulse_ab();
    @(negedge clk) begin le_ab = 1'b0; a_in = 18'h00011; end
    settle();
    chk("R5 last tracked word", b_out, 18'h2F00F);

    // R2 hold while input wiggles and clock is static
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) a_in = 18'h3FFFF ^ (18'h1 << i);
      settle();
      chk("R2 hold", b_out, 18'h2F00F);
    end

    // R3 capture on a gated-in edge
    @(negedge clk) begin cken_ab_n = 1'b0; a_in = 18'h3C3C3; end
    pulse_ab();
    @(negedge clk) a_in = 18'h00000;
    settle();
    chk("R3 capture", b_out, 18'h3C3C3);

    // R4 edges ignored with clock enable high
    @(negedge clk) begin cken_ab_n = 1'b1; a_in = 18'h12345; end
    pulse_ab(); pulse_ab();
    settle();
    chk("R4 gated edge ignored", b_out, 18'h3C3C3);

    // R6 release and restore keeps the stored word
    @(negedge clk) oe_ab_n = 1'b1;
    settle();
    chk("R6 released data", b_out, '0);
    chk("R6 released drive", {{(W-1){1'b0}}, b_drive}, '0);
    @(negedge clk) oe_ab_n = 1'b0;
    settle();
    chk("R6 restored word", b_out, 18'h3C3C3);
    chk("R6 restored drive", {{(W-1){1'b0}}, b_drive}, 18'h1);

    // R8 independence: B path capture leaves A path alone and vice versa
    @(negedge clk) begin b_in = 18'h0ABCD; cken_ba_n = 1'b0; end
    pulse_ba();
    settle();
    chk("R8 B path captured", a_out, 18'h0ABCD);
    chk("R8 A path untouched", b_out, 18'h3C3C3);
    @(negedge clk) begin cken_ab_n = 1'b0; a_in = 18'h21212; le_ab = 1'b1; end
    pulse_ab();
    @(negedge clk) le_ab = 1'b0;
    settle();
    chk("R8 A path moved", b_out, 18'h21212);
    chk("R8 B path untouched", a_out, 18'h0ABCD);
    @(negedge clk) begin le_ba = 1'b1; b_in = 18'h30303; end
    settle();
    chk("R1 B path transparent", a_out, 18'h30303);
    @(negedge clk) begin le_ba = 1'b0; b_in = 18'h0ABCD; end

    // R7 reset seen only on the path whose clock rises
    model_live = 1'b0;
    @(negedge clk) begin rst = 1'b1; le_ab = 1'b1; cken_ab_n = 1'b0; end
    pulse_ab();
    @(negedge clk) le_ab = 1'b0;
    settle();
    chk("R7 A path cleared", b_out, '0);
    chk("R7 B path kept", a_out, 18'h0ABCD);
    pulse_ba();
    settle();
    chk("R7 B path cleared", a_out, '0);
    @(negedge clk) rst = 1'b0;
    model_live = 1'b1;

    // Mixed stimulus checked every cycle against the model (R1..R6, R8)
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      case ($urandom % 6)
        0: a_in = W'($urandom);
        1: b_in = W'($urandom);
        2: begin le_ab = $urandom % 4 == 0; cken_ab_n = $urandom % 2 == 1;
                 oe_ab_n = $urandom % 5 == 0; end
        3: begin le_ba = $urandom % 4 == 0; cken_ba_n = $urandom % 2 == 1;
                 oe_ba_n = $urandom % 5 == 0; end
        4: clk_ab = ~clk_ab;
        default: clk_ba = ~clk_ba;
      endcase
    end

    settle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule